// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of address translations. Each lookup presents a virtual page number and an address-space tag. All stored entries are compared with that key in the same cycle. In the following cycle the block reports exactly one of three results: a hit that carries the frame number and the permission bits, a miss, or a permission fault. Because every entry carries the tag of the process that owns it, translations from several processes can sit in the buffer together, and a process switch does not require emptying it. An entry marked global matches whatever tag is presented, which suits kernel mappings.

After a miss, the surrounding logic walks the page table outside this block and then returns the translation through the fill port. The fill port first overwrites an entry that already matches the key. If none matches, it takes the lowest-numbered empty slot. If no slot is empty, it evicts the victim chosen by a tree of pseudo-LRU bits. That choice never lands on a locked entry, and a fill that finds every entry locked is refused with an error pulse.

A control port applies maintenance operations. It can empty the whole buffer, drop all of one process's entries, invalidate a single key, and lock or unlock a single key.

Top module: `tlb_assoc`

## Requirements
- R1: One cycle after a lookup request, `lk_hit` is high if a valid entry matches the key, and `lk_pfn` and `lk_perm` show that entry's stored values. An entry matches when its page number equals the request's and either its tag equals the request's or it is global. When several entries match, the lowest-numbered one is used. `lk_perm` bit 0 is read, bit 1 is write, bit 2 is execute.
- R2: A non-global entry matches only a request carrying its own tag. A global entry matches a request carrying any tag.
- R3: One cycle after a lookup request that matches no entry, `lk_miss` is high and `lk_pfn`/`lk_perm` read zero. In any cycle that follows no request, all three result flags are low. At most one of `lk_hit`, `lk_miss` and `lk_fault` is high at a time.
- R4: A write lookup (`lk_wr`=1) that matches an entry whose permission bit 1 is clear raises `lk_fault` instead of `lk_hit`. A write to an entry that has bit 1 set is an ordinary hit.
- R5: A fill whose key matches an existing entry rewrites that entry in place. Otherwise the fill goes to the lowest-numbered invalid entry.
- R6: When no entry is invalid, a fill replaces the entry selected by a binary tree of pseudo-LRU bits. The tree is walked from the root: a clear node bit picks the lower half and a set bit picks the upper half. Every hit and every fill flips the bits on its path so that they point away from the entry used. After reset all bits are clear.
- R7: A locked entry is never chosen as a victim. At each tree node the walk takes the other half when the indicated half holds only locked entries. A fill that matches no entry while all entries are locked writes nothing and pulses `fl_err` in the next cycle.
- R8: `ctl_op`=1 invalidates and unlocks every entry. A lookup in the following cycle misses.
- R9: `ctl_op`=2 invalidates the valid entries tagged `ctl_asid` that are neither global nor locked, and leaves all other entries as they were.
- R10: `ctl_op`=3 invalidates and unlocks the entries that match (`ctl_asid`, `ctl_vpn`). `ctl_op`=4 locks those entries and `ctl_op`=5 unlocks them. A fill sets the lock state from `fl_wired`.
- R11: After reset all entries are invalid and unlocked, and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_wr | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Write to an entry without write permission |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_perm | output | 3 | Permission bits of the matching entry |
| fl_req | input | 1 | Fill request |
| fl_asid | input | ASID_W | Fill tag |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_pfn | input | PFN_W | Fill frame number |
| fl_perm | input | 3 | Fill permission bits |
| fl_global | input | 1 | Fill entry ignores the tag on match |
| fl_wired | input | 1 | Fill entry is locked against replacement |
| fl_err | output | 1 | Fill refused because every entry is locked |
| ctl_op | input | 3 | 0 none, 1 flush all, 2 flush tag, 3 invalidate key, 4 lock key, 5 unlock key |
| ctl_asid | input | ASID_W | Tag operand of the control operation |
| ctl_vpn | input | VPN_W | Page operand of the control operation |

## Verification
Directed sequences separate same-tag, other-tag and global matches. They also separate read hits from write faults, an in-place refill from a fresh allocation, and each maintenance operation's effect on global and locked neighbours. One sequence fills all sixteen slots and then overfills, so that the pseudo-LRU victim is exposed by the later lookups. A second sequence locks every slot, which forces the refusal path, and then unlocks one slot to show that the walk detours to it. A long random run uses a narrow range of pages and tags, so hits, duplicates, evictions and locked exclusions occur often. Every result in that run is compared against a range-based reference model kept in the bench.

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int NE     = 16,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_wr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_perm,
  input  logic              fl_req,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PFN_W-1:0]  fl_pfn,
  input  logic [2:0]        fl_perm,
  input  logic              fl_global,
  input  logic              fl_wired,
  output logic              fl_err,
  input  logic [2:0]        ctl_op,
  input  logic [ASID_W-1:0] ctl_asid,
  input  logic [VPN_W-1:0]  ctl_vpn
);
  localparam int LG = $clog2(NE);
  localparam logic [2:0] OP_FLUSH = 3'd1, OP_FASID = 3'd2, OP_INV = 3'd3,
                         OP_WIRE = 3'd4, OP_UNWIRE = 3'd5;

  logic [NE-1:0]     ev, eg, ew;
  logic [ASID_W-1:0] ea [NE];
  logic [VPN_W-1:0]  evp [NE];
  logic [PFN_W-1:0]  epf [NE];
  logic [2:0]        epm [NE];
  logic [NE-1:1]     plru, plru_n;

  logic [NE-1:0] lk_m, fl_m, ct_m;
  logic [2*NE-1:1] av;
  logic [LG-1:0] lk_idx, fl_hidx, inv_idx, vic, fl_idx;
  logic lk_any, lk_flt, fl_any, fl_do;

  function automatic logic [LG-1:0] first(input logic [NE-1:0] m);
    logic [LG-1:0] r;
    r = '0;
    for (int i = NE-1; i >= 0; i--) if (m[i]) r = LG'(i);
    return r;
  endfunction

  function automatic logic [NE-1:1] touch(input logic [NE-1:1] p, input logic [LG-1:0] e);
    int node;
    logic b;
    node = 1;
    for (int l = 0; l < LG; l++) begin
      b = e[LG-1-l];
      p[node] = ~b;
      node = 2*node + int'(b);
    end
    return p;
  endfunction

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      lk_m[i] = ev[i] && evp[i] == lk_vpn  && (eg[i] || ea[i] == lk_asid);
      fl_m[i] = ev[i] && evp[i] == fl_vpn  && (eg[i] || ea[i] == fl_asid);
      ct_m[i] = ev[i] && evp[i] == ctl_vpn && (eg[i] || ea[i] == ctl_asid);
    end
  end

  assign lk_any  = |lk_m;
  assign lk_idx  = first(lk_m);
  assign lk_flt  = lk_wr && !epm[lk_idx][1];
  assign fl_any  = |fl_m;
  assign fl_hidx = first(fl_m);
  assign inv_idx = first(~ev);

  always_comb begin
    int node;
    logic d;
    av = '0;
    for (int i = 0; i < NE; i++) av[NE+i] = ~ew[i];
    for (int k = NE-1; k >= 1; k--) av[k] = av[2*k] | av[2*k+1];
    node = 1;
    for (int l = 0; l < LG; l++) begin
      d = plru[node];
      if (!av[2*node + int'(d)]) d = ~d;
      node = 2*node + int'(d);
    end
    vic = LG'(node - NE);
  end

  assign fl_idx = fl_any ? fl_hidx : (~&ev) ? inv_idx : vic;
  assign fl_do  = fl_req && (fl_any || av[1]);

  always_comb begin
    plru_n = plru;
    if (lk_req && lk_any && !lk_flt) plru_n = touch(plru_n, lk_idx);
    if (fl_do) plru_n = touch(plru_n, fl_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= '0; eg <= '0; ew <= '0; plru <= '0;
      lk_hit <= 1'b0; lk_miss <= 1'b0; lk_fault <= 1'b0;
      lk_pfn <= '0; lk_perm <= '0; fl_err <= 1'b0;
      for (int i = 0; i < NE; i++) begin
        ea[i] <= '0; evp[i] <= '0; epf[i] <= '0; epm[i] <= '0;
      end
    end else begin
      lk_hit   <= lk_req && lk_any && !lk_flt;
      lk_fault <= lk_req && lk_any && lk_flt;
      lk_miss  <= lk_req && !lk_any;
      lk_pfn   <= (lk_req && lk_any) ? epf[lk_idx] : '0;
      lk_perm  <= (lk_req && lk_any) ? epm[lk_idx] : '0;
      fl_err   <= fl_req && !fl_do;
      plru     <= plru_n;
      for (int i = 0; i < NE; i++) begin
        case (ctl_op)
          OP_FLUSH:  begin ev[i] <= 1'b0; ew[i] <= 1'b0; end
          OP_FASID:  if (ev[i] && !eg[i] && !ew[i] && ea[i] == ctl_asid) ev[i] <= 1'b0;
          OP_INV:    if (ct_m[i]) begin ev[i] <= 1'b0; ew[i] <= 1'b0; end
          OP_WIRE:   if (ct_m[i]) ew[i] <= 1'b1;
          OP_UNWIRE: if (ct_m[i]) ew[i] <= 1'b0;
          default: ;
        endcase
      end
      if (fl_do) begin
        ev[fl_idx]  <= 1'b1;
        eg[fl_idx]  <= fl_global;
        ew[fl_idx]  <= fl_wired;
        ea[fl_idx]  <= fl_asid;
        evp[fl_idx] <= fl_vpn;
        epf[fl_idx] <= fl_pfn;
        epm[fl_idx] <= fl_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_req,
  input logic       lk_wr,
  input logic       lk_hit,
  input logic       lk_miss,
  input logic       lk_fault,
  input logic       fl_req,
  input logic       fl_err,
  input logic [2:0] ctl_op
);
  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));

  assert_req_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> $countones({lk_hit, lk_miss, lk_fault}) == 1);

  assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_hit && !lk_miss && !lk_fault);

  assert_fault_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_wr |=> !lk_fault);

  assert_err_needs_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_req |=> !fl_err);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_op == 3'd1 && !fl_req) ##1 lk_req |=> !lk_hit && !lk_fault);
endmodule

bind tlb_assoc tlb_assoc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_wr(lk_wr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
  .fl_req(fl_req), .fl_err(fl_err), .ctl_op(ctl_op)
);

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16, AW = 8, VW = 20, PW = 20;

  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_wr = 0, fl_req = 0, fl_global = 0, fl_wired = 0;
  logic [AW-1:0] lk_asid = 0, fl_asid = 0, ctl_asid = 0;
  logic [VW-1:0] lk_vpn = 0, fl_vpn = 0, ctl_vpn = 0;
  logic [PW-1:0] fl_pfn = 0;
  logic [2:0] fl_perm = 0, ctl_op = 0;
  logic lk_hit, lk_miss, lk_fault, fl_err;
  logic [PW-1:0] lk_pfn;
  logic [2:0] lk_perm;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc u_tlb_assoc (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_wr(lk_wr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fl_req(fl_req), .fl_asid(fl_asid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
    .fl_perm(fl_perm), .fl_global(fl_global), .fl_wired(fl_wired), .fl_err(fl_err),
    .ctl_op(ctl_op), .ctl_asid(ctl_asid), .ctl_vpn(ctl_vpn)
  );

  bit mv[NE], mg[NE], mw[NE];
  logic [AW-1:0] ma[NE];
  logic [VW-1:0] mvp[NE];
  logic [PW-1:0] mpf[NE];
  logic [2:0] mpm[NE];
  bit mp[1:NE-1];

  function automatic int fm(input logic [AW-1:0] a, input logic [VW-1:0] v);
    for (int i = 0; i < NE; i++)
      if (mv[i] && mvp[i] == v && (mg[i] || ma[i] == a)) return i;
    return -1;
  endfunction

  function automatic int pick();
    int lo, sz, nd, h;
    bit r, lok, rok;
    lo = 0; sz = NE; nd = 1;
    while (sz > 1) begin
      h = sz / 2; r = mp[nd]; lok = 0; rok = 0;
      for (int j = 0; j < h; j++) begin
        if (!mw[lo+j]) lok = 1;
        if (!mw[lo+h+j]) rok = 1;
      end
      if (r && !rok) r = 0;
      else if (!r && !lok) r = 1;
      if (r) lo += h;
      nd = 2*nd + int'(r); sz = h;
    end
    return lo;
  endfunction

  function automatic void mtouch(input int e);
    int lo, sz, nd, h;
    bit r;
    lo = 0; sz = NE; nd = 1;
    while (sz > 1) begin
      h = sz / 2; r = (e >= lo + h);
      mp[nd] = !r;
      if (r) lo += h;
      nd = 2*nd + int'(r); sz = h;
    end
  endfunction

  task automatic idle_inputs();
    lk_req = 0; lk_wr = 0; fl_req = 0; fl_global = 0; fl_wired = 0; ctl_op = 0;
  endtask

  task automatic cycle(input string tag);
    int li, fi, t;
    bit eh, em, ef, ee, allw;
    logic [PW-1:0] ep;
    logic [2:0] epr;
    li = lk_req ? fm(lk_asid, lk_vpn) : -1;
    ef = li >= 0 && lk_wr && !mpm[li][1];
    eh = li >= 0 && !ef;
    em = lk_req && li < 0;
    ep = li >= 0 ? mpf[li] : '0;
    epr = li >= 0 ? mpm[li] : '0;
    t = -1;
    if (fl_req) begin
      fi = fm(fl_asid, fl_vpn);
      allw = 1;
      for (int i = 0; i < NE; i++) if (!mw[i]) allw = 0;
      if (fi >= 0) t = fi;
      else begin
        for (int i = NE-1; i >= 0; i--) if (!mv[i]) t = i;
        if (t < 0 && !allw) t = pick();
      end
    end
    ee = fl_req && t < 0;
    if (eh) mtouch(li);
    if (t >= 0) mtouch(t);
    for (int i = 0; i < NE; i++) begin
      case (ctl_op)
        3'd1: begin mv[i] = 0; mw[i] = 0; end
        3'd2: if (mv[i] && !mg[i] && !mw[i] && ma[i] == ctl_asid) mv[i] = 0;
        3'd3: if (mv[i] && mvp[i] == ctl_vpn && (mg[i] || ma[i] == ctl_asid)) begin mv[i] = 0; mw[i] = 0; end
        3'd4: if (mv[i] && mvp[i] == ctl_vpn && (mg[i] || ma[i] == ctl_asid)) mw[i] = 1;
        3'd5: if (mv[i] && mvp[i] == ctl_vpn && (mg[i] || ma[i] == ctl_asid)) mw[i] = 0;
        default: ;
      endcase
    end
    if (t >= 0) begin
      mv[t] = 1; mg[t] = fl_global; mw[t] = fl_wired; ma[t] = fl_asid;
      mvp[t] = fl_vpn; mpf[t] = fl_pfn; mpm[t] = fl_perm;
    end
    @(posedge clk); #1;
    checks++;
    if ({lk_hit, lk_miss, lk_fault, fl_err} !== {eh, em, ef, ee} || lk_pfn !== ep || lk_perm !== epr) begin
      errors++;
      $display("FAIL %s: hit/miss/fault/err=%b%b%b%b pfn=%h perm=%b expected %b%b%b%b pfn=%h perm=%b",
               tag, lk_hit, lk_miss, lk_fault, fl_err, lk_pfn, lk_perm, eh, em, ef, ee, ep, epr);
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_fill(input int a, input int v, input int p, input logic [2:0] pm,
                         input bit g, input bit w, input string tag);
    fl_req = 1; fl_asid = AW'(a); fl_vpn = VW'(v); fl_pfn = PW'(p);
    fl_perm = pm; fl_global = g; fl_wired = w;
    cycle(tag);
  endtask

  task automatic do_look(input int a, input int v, input bit wr, input string tag);
    lk_req = 1; lk_asid = AW'(a); lk_vpn = VW'(v); lk_wr = wr;
    cycle(tag);
  endtask

  task automatic do_ctl(input logic [2:0] op, input int a, input int v, input string tag);
    ctl_op = op; ctl_asid = AW'(a); ctl_vpn = VW'(v);
    cycle(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1d5c);
    for (int i = 0; i < NE; i++) begin mv[i] = 0; mg[i] = 0; mw[i] = 0; end
    for (int i = 1; i < NE; i++) mp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if ({lk_hit, lk_miss, lk_fault, fl_err} !== 4'b0 || lk_pfn !== '0 || lk_perm !== '0) begin
      errors++;
      $display("FAIL R11: outputs=%b%b%b%b pfn=%h expected all zero", lk_hit, lk_miss, lk_fault, fl_err, lk_pfn);
    end
    do_look(1, 'h10, 0, "R11");

    do_fill(1, 'h10, 'h100, 3'b011, 0, 0, "R5");
    do_look(1, 'h10, 0, "R1");
    do_look(2, 'h10, 0, "R2");
    do_fill(0, 'h20, 'h200, 3'b101, 1, 0, "R5");
    do_look(3, 'h20, 0, "R2");
    do_look(3, 'h20, 1, "R4");
    do_look(1, 'h10, 1, "R4");
    do_look(1, 'h99, 0, "R3");
    do_fill(1, 'h10, 'h155, 3'b001, 0, 0, "R5");
    do_look(1, 'h10, 0, "R5");
    do_fill(2, 'h30, 'h300, 3'b011, 0, 0, "R5");
    do_fill(1, 'h31, 'h301, 3'b011, 0, 0, "R5");
    do_ctl(3'd2, 1, 0, "R9");
    do_look(1, 'h10, 0, "R9");
    do_look(1, 'h20, 0, "R9");
    do_look(2, 'h30, 0, "R9");
    do_ctl(3'd4, 2, 'h30, "R10");
    do_ctl(3'd2, 2, 0, "R9");
    do_look(2, 'h30, 0, "R9");
    do_ctl(3'd3, 2, 'h30, "R10");
    do_look(2, 'h30, 0, "R10");
    do_ctl(3'd1, 0, 0, "R8");
    do_look(7, 'h20, 0, "R8");

    for (int i = 0; i < NE; i++) do_fill(1, 'h40 + i, 'h500 + i, 3'b111, 0, 0, "R6");
    do_look(1, 'h45, 0, "R6");
    do_look(1, 'h4a, 0, "R6");
    do_fill(1, 'h80, 'h880, 3'b111, 0, 0, "R6");
    do_fill(1, 'h81, 'h881, 3'b111, 0, 0, "R6");
    for (int i = 0; i < NE; i++) do_look(1, 'h40 + i, 0, "R6");
    do_look(1, 'h80, 0, "R6");

    do_ctl(3'd1, 0, 0, "R8");
    for (int i = 0; i < NE; i++) do_fill(2, 'h60 + i, 'h600 + i, 3'b011, 0, 1, "R7");
    do_fill(2, 'h90, 'h990, 3'b011, 0, 0, "R7");
    do_look(2, 'h90, 0, "R7");
    do_fill(2, 'h63, 'h777, 3'b011, 0, 1, "R5");
    do_look(2, 'h63, 0, "R5");
    do_ctl(3'd5, 2, 'h6b, "R10");
    do_fill(2, 'h91, 'h991, 3'b011, 0, 0, "R7");
    do_look(2, 'h6b, 0, "R7");
    do_look(2, 'h91, 0, "R7");
    do_ctl(3'd1, 0, 0, "R8");

    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 8) begin
        ctl_op = 3'($urandom_range(1, 5));
        if (ctl_op == 3'd1 && $urandom_range(0, 3) != 0) ctl_op = 3'd2;
        ctl_asid = AW'($urandom_range(0, 3)); ctl_vpn = VW'($urandom_range(0, 23));
      end else begin
        if (k < 45) begin
          fl_req = 1; fl_asid = AW'($urandom_range(0, 3)); fl_vpn = VW'($urandom_range(0, 23));
          fl_pfn = PW'($urandom); fl_perm = 3'($urandom);
          fl_global = ($urandom_range(0, 9) == 0); fl_wired = ($urandom_range(0, 7) == 0);
        end
        if (k >= 30) begin
          lk_req = 1; lk_asid = AW'($urandom_range(0, 3)); lk_vpn = VW'($urandom_range(0, 23));
          lk_wr = $urandom_range(0, 2) == 0;
        end
      end
      cycle("R6");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule